// File: doc/BRIEF.md
# Dual-Tone Burst Generator

This block produces a digital dual-tone signal for a voice-band transmit or receive path. Two tone channels each step through a 16-entry stepped sine. A low channel uses a clock multiple of 14 per divisor unit and a high channel uses a multiple of 6. Each channel's frequency comes from an 8-bit divisor code. The two 8-bit signed samples are added into one 9-bit signed sample, and that sample is registered. With a 1.2 MHz clock, the low tone frequency is 1.2 MHz / (14·D) and the high tone frequency is 1.2 MHz / (6·D).

Writing the low divisor starts a burst. A timer of `BURST_CLKS` clocks runs, which is 96 ms at 1.2 MHz. When the timer expires, each tone runs on to its next zero-level step and then halts, so a burst can outlast the timer by up to half of a tone cycle. A continuous flag holds the timer, so the tones keep running. Rewriting a divisor during a run changes the pitch and keeps the current waveform step. A few reserved codes select the slowest pitch, and one code mutes a tone, which gives a single tone. When the enable input is low, the whole generator is held idle.

Top module: `dual_tone_gen`

## Requirements
- R1: While reset is active and after reset is released, `busy` is 0 and `sample` is 0.
- R2: A running tone's step index is floor(16·n / (M·D)) mod 16 after n clocks from its start, with M = 14 for the low channel and M = 6 for the high channel. This makes the periods exactly 14·D and 6·D clocks. Step k outputs round(127·sin(2πk/16)), so steps 0 and 8 are zero.
- R3: `sample` is the sum of both channels' step values, registered one clock after the channel state. A channel that is not running contributes 0, so `sample` is 0 in the clock after `busy` is 0.
- R4: A `lo_wr` while enabled starts a burst. It clears the timer and starts each channel whose divisor is not the mute code. A `hi_wr` alone never starts a burst.
- R5: With `cont` at 0, once `BURST_CLKS` clocks have passed since the start, a channel halts at the first edge where its step advances onto step 0 or step 8. `busy` falls when both channels have halted.
- R6: While `cont` is 1, the timer does not advance and the tones run without end.
- R7: Divisor codes 0 and 1 select an effective divisor of 256 on the low channel and 257 on the high channel.
- R8: Divisor code 2 mutes its channel. A muted channel is not started, and writing 2 to a running channel halts it at once.
- R9: Writing a new non-mute divisor to a running channel keeps its step index, clears its fractional phase, and steps at the new rate from that edge on.
- R10: While `en` is 0, no channel runs, writes start nothing, and `sample` returns to 0 one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (1.2 MHz nominal) |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Generator enable; low holds the block idle |
| lo_wr | input | 1 | Low divisor write strobe; also starts a burst |
| lo_code | input | 8 | Low channel divisor code |
| hi_wr | input | 1 | High divisor write strobe |
| hi_code | input | 8 | High channel divisor code |
| cont | input | 1 | Continuous mode; holds the burst timer |
| sample | output | 9 | Signed sum of both channels |
| busy | output | 1 | High while either channel runs |

## Verification
The main function is swept over a grid of low and high divisors, from the smallest legal codes up to moderate ones, in continuous mode. The sample is compared every clock against the floor(16n/(M·D)) step formula. Small codes expose any off-by-one error in the fractional phase, and mixed pairs show whether the two channels are kept apart and summed. Timed bursts with single tones and with two tones locate the exact halting edge after the timer, which separates a zero-crossing stop from a plain timer cutoff. Reserved codes, the mute code, mid-run divisor rewrites and enable drops each get their own runs. These runs show the 256/257 mapping, immediate muting and phase continuity.

// File: rtl/dtg_pkg.sv
package dtg_pkg;

  localparam int STEPS   = 16;
  localparam int PH_W    = 4;
  localparam int MAX_DIV = 257;
  localparam int CODE_W  = 8;
  localparam int SMP_W   = 8;
  localparam int DIV_W   = 9;
  localparam int NCH     = 2;

  localparam logic [CODE_W-1:0] CODE_MUTE = 8'd2;

  // Effective divisor; 0 means the channel is muted.
  function automatic logic [DIV_W-1:0] eff_div(input logic [CODE_W-1:0] code,
                                               input logic hi_sel);
    logic [DIV_W-1:0] r;
    if (code == CODE_MUTE)      r = '0;
    else if (code < CODE_MUTE)  r = hi_sel ? 9'd257 : 9'd256;
    else                        r = {1'b0, code};
    return r;
  endfunction

  // 16-step sine scaled to 127, built from the first half wave.
  function automatic logic signed [SMP_W-1:0] sine_lut(input logic [PH_W-1:0] k);
    logic [SMP_W-1:0] mag;
    case (k[2:0])
      3'd0: mag = 8'd0;
      3'd1: mag = 8'd49;
      3'd2: mag = 8'd90;
      3'd3: mag = 8'd117;
      3'd4: mag = 8'd127;
      3'd5: mag = 8'd117;
      3'd6: mag = 8'd90;
      default: mag = 8'd49;
    endcase
    return k[3] ? -$signed(mag) : $signed(mag);
  endfunction

endpackage

// File: rtl/dtg_tone_chan.sv
module dtg_tone_chan
  import dtg_pkg::*;
#(
  parameter int MULT   = 14,
  parameter bit HI_SEL = 1'b0
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en,
  input  logic                    wr,
  input  logic [CODE_W-1:0]       code,
  input  logic                    start,
  input  logic                    stop_req,
  output logic                    run_o,
  output logic signed [SMP_W-1:0] smp_o
);

  localparam int LIM_W = $clog2(MULT*MAX_DIV + 1);
  localparam logic [LIM_W:0] MULT_X  = (LIM_W+1)'(MULT);
  localparam logic [LIM_W:0] STEP_X  = (LIM_W+1)'(STEPS);

  logic [DIV_W-1:0] div_q, div_n;
  logic [LIM_W-1:0] acc_q, acc_n;
  logic [PH_W-1:0]  step_q, step_n;
  logic             run_q, run_n;

  logic [DIV_W-1:0] new_div, start_div;
  logic [LIM_W:0]   limit, sum_acc, wrap_acc;
  logic [PH_W-1:0]  step_inc;
  logic             tick, lands_zero;

  always_comb begin
    new_div    = eff_div(code, HI_SEL);
    limit      = MULT_X * (LIM_W+1)'(div_q);
    sum_acc    = {1'b0, acc_q} + STEP_X;
    wrap_acc   = sum_acc - limit;
    tick       = run_q && (sum_acc >= limit);
    step_inc   = step_q + 1'b1;
    lands_zero = (step_inc[PH_W-2:0] == '0);
    start_div  = wr ? new_div : div_q;

    div_n  = wr ? new_div : div_q;
    acc_n  = acc_q;
    step_n = step_q;
    run_n  = run_q;

    if (!en) begin
      run_n  = 1'b0;
      acc_n  = '0;
      step_n = '0;
    end else begin
      if (run_q) begin
        acc_n  = tick ? wrap_acc[LIM_W-1:0] : sum_acc[LIM_W-1:0];
        step_n = tick ? step_inc : step_q;
        if (tick && stop_req && lands_zero) begin
          run_n  = 1'b0;
          acc_n  = '0;
          step_n = '0;
        end
      end
      if (wr) begin
        acc_n = '0;
        if (run_n) step_n = step_q;
        if (new_div == '0) begin
          run_n  = 1'b0;
          step_n = '0;
        end
      end
      if (start && (start_div != '0)) run_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      acc_q  <= '0;
      step_q <= '0;
      run_q  <= 1'b0;
    end else begin
      div_q  <= div_n;
      acc_q  <= acc_n;
      step_q <= step_n;
      run_q  <= run_n;
    end
  end

  assign run_o = run_q;
  assign smp_o = run_q ? sine_lut(step_q) : '0;

endmodule

// File: rtl/dtg_burst_timer.sv
module dtg_burst_timer #(
  parameter int BURST_CLKS = 115200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic start,
  input  logic cont,
  output logic stop_req
);

  localparam int CNT_W = $clog2(BURST_CLKS + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BURST_CLKS);

  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             expired, cnt_en;

  always_comb begin
    expired = (cnt_q == LAST);
    cnt_en  = !cont && !expired;
    cnt_n   = cnt_q;
    if (!en)         cnt_n = LAST;
    else if (start)  cnt_n = '0;
    else if (cnt_en) cnt_n = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= LAST;
    else        cnt_q <= cnt_n;
  end

  assign stop_req = expired && !cont;

endmodule

// File: rtl/dtg_mixer.sv
module dtg_mixer
  import dtg_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic signed [SMP_W-1:0] a,
  input  logic signed [SMP_W-1:0] b,
  output logic signed [SMP_W:0]   sum_o
);

  logic signed [SMP_W:0] sum_q, sum_n;

  always_comb begin
    sum_n = {a[SMP_W-1], a} + {b[SMP_W-1], b};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sum_q <= '0;
    else        sum_q <= sum_n;
  end

  assign sum_o = sum_q;

endmodule

// File: rtl/dual_tone_gen.sv
module dual_tone_gen
  import dtg_pkg::*;
#(
  parameter int BURST_CLKS = 115200,
  parameter int LO_MULT    = 14,
  parameter int HI_MULT    = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              lo_wr,
  input  logic [7:0]        lo_code,
  input  logic              hi_wr,
  input  logic [7:0]        hi_code,
  input  logic              cont,
  output logic signed [8:0] sample,
  output logic              busy
);

  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  logic                    stop_req, burst_go;
  logic [NCH-1:0]          wr_v, run_v;
  logic [CODE_W-1:0]       code_v [NCH];
  logic signed [SMP_W-1:0] smp_v  [NCH];

  assign burst_go  = en && lo_wr;
  assign wr_v      = {hi_wr, lo_wr};
  assign code_v[0] = lo_code;
  assign code_v[1] = hi_code;

  dtg_burst_timer #(.BURST_CLKS(BURST_CLKS)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .en       (en),
    .start    (burst_go),
    .cont     (cont),
    .stop_req (stop_req)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    dtg_tone_chan #(
      .MULT   ((g == 0) ? LO_MULT : HI_MULT),
      .HI_SEL (g == 1)
    ) u_ch (
      .clk      (clk),
      .rst_n    (rst_sync_n),
      .en       (en),
      .wr       (wr_v[g]),
      .code     (code_v[g]),
      .start    (burst_go),
      .stop_req (stop_req),
      .run_o    (run_v[g]),
      .smp_o    (smp_v[g])
    );
  end

  dtg_mixer u_mix (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .a     (smp_v[0]),
    .b     (smp_v[1]),
    .sum_o (sample)
  );

  assign busy = |run_v;

endmodule

// File: rtl/dtg_checker.sv
module dtg_checker (
  input logic              clk,
  input logic              rst_n,
  input logic              en,
  input logic              lo_wr,
  input logic [7:0]        lo_code,
  input logic              hi_wr,
  input logic              cont,
  input logic signed [8:0] sample,
  input logic              busy
);

  a_r3_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> (sample == 9'sd0));

  a_r10_disable: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !busy);

  a_r6_cont_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (en && cont && busy && !hi_wr && !lo_wr) |=> busy);

  a_r4_hi_no_start: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !busy && hi_wr && !lo_wr) |=> !busy);

  a_r4_lo_start: assert property (@(posedge clk) disable iff (!rst_n)
    (en && lo_wr && (lo_code != 8'd2)) |=> busy);

  always @(posedge clk) begin
    if (rst_n) begin
      a_r3_range: assert (int'(sample) <= 254 && int'(sample) >= -254);
    end
  end

endmodule

bind dual_tone_gen dtg_checker u_chk (
  .clk     (clk),
  .rst_n   (rst_sync_n),
  .en      (en),
  .lo_wr   (lo_wr),
  .lo_code (lo_code),
  .hi_wr   (hi_wr),
  .cont    (cont),
  .sample  (sample),
  .busy    (busy)
);

// File: tb/sim_dual_tone_gen.sv
module sim_dual_tone_gen;

  localparam int B = 500;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              en = 1'b0;
  logic              lo_wr = 1'b0;
  logic [7:0]        lo_code = 8'd0;
  logic              hi_wr = 1'b0;
  logic [7:0]        hi_code = 8'd0;
  logic              cont = 1'b0;
  logic signed [8:0] sample;
  logic              busy;

  int vec = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dual_tone_gen #(.BURST_CLKS(B)) u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .lo_wr(lo_wr), .lo_code(lo_code),
    .hi_wr(hi_wr), .hi_code(hi_code), .cont(cont), .sample(sample), .busy(busy)
  );

  task automatic chk(input string req, input int act, input int exp);
    vec++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int sref(input int k);
    real v;
    v = 127.0 * $sin(2.0 * 3.141592653589793 * k / 16.0);
    return (v >= 0.0) ? $rtoi(v + 0.5) : -$rtoi(-v + 0.5);
  endfunction

  // Clock count of one tone period for a code (0 = muted): R2, R7, R8
  function automatic int per(input int code, input bit hi);
    if (code == 2) return 0;
    if (code < 2)  return hi ? 6*257 : 14*256;
    return hi ? 6*code : 14*code;
  endfunction

  // Edge index at which a tone halts after the timer: R5
  function automatic int mstar(input int L);
    if (L == 0) return 0;
    for (int m = B + 1; m < B + 2*L + 4; m++)
      if ((16*m/L > 16*(m-1)/L) && ((16*m/L) % 8 == 0)) return m;
    return -1;
  endfunction

  task automatic clear_all();
    @(negedge clk); en = 1'b0; lo_wr = 1'b0; hi_wr = 1'b0;
    @(negedge clk); en = 1'b1;
  endtask

  task automatic put_hi(input int code);
    hi_code = 8'(code); hi_wr = 1'b1;
    @(negedge clk); hi_wr = 1'b0;
  endtask

  task automatic put_lo(input int code);
    lo_code = 8'(code); lo_wr = 1'b1;
    @(negedge clk); lo_wr = 1'b0;
  endtask

  // Burst run compared every clock against the step formula
  task automatic run_burst(input string req, input int dl, input int dh,
                           input bit c, input int len);
    int Ll, Lh, ml, mh, e;
    bit b;
    Ll = per(dl, 1'b0); Lh = per(dh, 1'b1);
    ml = mstar(Ll); mh = mstar(Lh);
    clear_all();
    cont = c;
    put_hi(dh);
    put_lo(dl);
    for (int m = 1; m <= len; m++) begin
      @(negedge clk);
      e = 0;
      if (Ll > 0 && (c || (m-1) < ml)) e += sref((16*(m-1)/Ll) % 16);
      if (Lh > 0 && (c || (m-1) < mh)) e += sref((16*(m-1)/Lh) % 16);
      b = (Ll > 0 && (c || m < ml)) || (Lh > 0 && (c || m < mh));
      chk({req, " sample"}, int'(sample), e);
      chk({req, " busy"}, int'(busy), int'(b));
    end
  endtask

  // Continuous run with a high divisor rewrite at edge w: R9, R8
  task automatic run_rewrite(input string req, input int dl, input int dh1,
                             input int dh2, input int w, input int len);
    int Ll, L1, L2, s0, e;
    bit b;
    Ll = per(dl, 1'b0); L1 = per(dh1, 1'b1); L2 = per(dh2, 1'b1);
    s0 = (16*(w-1)/L1) % 16;
    clear_all();
    cont = 1'b1;
    put_hi(dh1);
    put_lo(dl);
    for (int m = 1; m <= len; m++) begin
      if (m == w) begin hi_code = 8'(dh2); hi_wr = 1'b1; end
      else hi_wr = 1'b0;
      @(negedge clk);
      e = 0;
      if (Ll > 0) e += sref((16*(m-1)/Ll) % 16);
      if ((m-1) < w) e += sref((16*(m-1)/L1) % 16);
      else if (L2 > 0) e += sref((s0 + 16*(m-1-w)/L2) % 16);
      b = (Ll > 0) || (m < w) || (L2 > 0);
      chk({req, " sample"}, int'(sample), e);
      chk({req, " busy"}, int'(busy), int'(b));
    end
    hi_wr = 1'b0;
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vec, fails);
      $finish;
    end
  end

  initial begin : main
    int lo_set [6] = '{3, 4, 5, 7, 11, 20};
    int hi_set [3] = '{3, 9, 50};
    repeat (3) @(negedge clk);
    chk("R1 reset sample", int'(sample), 0);
    chk("R1 reset busy", int'(busy), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 post-reset sample", int'(sample), 0);
    chk("R1 post-reset busy", int'(busy), 0);

    // R2 R3: continuous sweep over divisor pairs
    foreach (lo_set[i])
      foreach (hi_set[j])
        run_burst("R2 R3 sweep", lo_set[i], hi_set[j], 1'b1, 400);

    // R5: timed bursts, single and dual tone
    run_burst("R5 lo only", 20, 2, 1'b0, mstar(280) + 8);
    run_burst("R5 hi only", 2, 17, 1'b0, mstar(102) + 8);
    run_burst("R5 both", 25, 40, 1'b0, mstar(350) + 8);
    run_burst("R5 lo short", 3, 2, 1'b0, mstar(42) + 8);

    // R6: continuous well past the timer length
    run_burst("R6 continuous", 13, 21, 1'b1, 3*B);

    // R7: reserved codes
    run_burst("R7 codes 0/1", 0, 1, 1'b1, 3700);
    run_burst("R7 codes 1/0", 1, 0, 1'b1, 1700);

    // R8: mute code on either channel, and no start when both muted
    run_burst("R8 lo muted", 2, 11, 1'b1, 300);
    run_burst("R8 both muted", 2, 2, 1'b0, 20);
    run_rewrite("R8 mute mid-run", 9, 14, 2, 150, 400);

    // R9: phase-continuous rewrite
    run_rewrite("R9 rewrite up", 6, 30, 11, 137, 600);
    run_rewrite("R9 rewrite down", 2, 8, 45, 61, 700);

    // R4: high write alone starts nothing
    clear_all();
    cont = 1'b0;
    put_hi(9);
    for (int m = 0; m < 20; m++) begin
      @(negedge clk);
      chk("R4 hi write no start busy", int'(busy), 0);
      chk("R4 hi write no start sample", int'(sample), 0);
    end

    // R10: writes while disabled, then enable drop mid-burst
    @(negedge clk); en = 1'b0;
    put_lo(20);
    for (int m = 0; m < 10; m++) begin
      @(negedge clk);
      chk("R10 disabled busy", int'(busy), 0);
      chk("R10 disabled sample", int'(sample), 0);
    end
    en = 1'b1;
    put_hi(5);
    put_lo(5);
    repeat (30) @(negedge clk);
    chk("R4 lo write starts busy", int'(busy), 1);
    en = 1'b0;
    @(negedge clk);
    chk("R10 drop busy", int'(busy), 0);
    @(negedge clk);
    chk("R10 drop sample", int'(sample), 0);
    en = 1'b1;

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vec, fails);
    $finish;
  end

endmodule